// File: doc/BRIEF.md
# Precise Sampling Record Writer

This block joins one event counter to a record writer. Software presets the counter so that it wraps after a chosen number of events. On the event that wraps it, the block takes a snapshot of an architectural state vector: an instruction pointer, a flags word and a set of general registers. It then writes that snapshot as a fixed-size record of 64-bit words into a linear memory buffer. The counter is preset again in the same cycle and keeps counting.

The buffer is tracked by a write index, an absolute limit and an interrupt threshold. The index only grows; it never wraps back to the start. A sticky interrupt tells software that the buffer is nearly full and should be drained. Once the index has reached the limit, further wraps still re-preset the counter, but they write nothing and set a sticky full flag instead.

A wrap that arrives while a record is still being written is held as pending. It is serviced as soon as the write ends.

Top module: `prec_sample_writer`

## Requirements
- R1: After reset, `mem_valid`, `irq` and `buf_full` are 0 and `idx_out` is 0.
- R2: A pulse on `preset_wr` loads `preset_val` into the counter. Each cycle with `count_en` and `event_in` both high adds one. The event that meets the all-ones value is the wrap: it reloads `preset_val`. With preset P and width W, the wrap is event number 2^W − P.
- R3: A record is NUM_GPR+2 words, taken from the state inputs in the cycle the wrap is serviced. Word 0 is `state_ip` and word 1 is `state_flags`. Word 2+k is general register k, which sits at bits [64k+63:64k] of `state_gpr`. Word j goes to address `idx_out + 8*j`.
- R4: `mem_addr` and `mem_data` hold steady while `mem_valid` is high and `mem_ready` is low. `idx_out` grows by 8*(NUM_GPR+2) only in the cycle after the last word is accepted.
- R5: `irq` rises in the same cycle as the index update whose new value is at or above `irq_thresh`. It stays high until `irq_clr`. If a set and a clear fall in the same cycle, the set wins.
- R6: If a wrap is serviced while `idx_out >= abs_max`, no word is written, `idx_out` does not change and `buf_full` is set. The counter is still re-preset. `buf_full` stays set until an accepted index write clears it.
- R7: A wrap that arrives while a record is in flight is kept and serviced after the current record ends. Its record goes to the next index.
- R8: While `count_en` is low, events do not count. Dropping `count_en` during a record does not stop that record.
- R9: `idx_wr` loads `idx_wdata` when no record is in flight. It is ignored while a record is being written.
- R10: Apart from an index write, `idx_out` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Counting enable |
| event_in | input | 1 | Event strobe, one per cycle |
| preset_wr | input | 1 | Load the preset into the counter |
| preset_val | input | CNT_W | Preset and reload value |
| state_ip | input | 64 | Instruction pointer to capture |
| state_flags | input | 64 | Flags word to capture |
| state_gpr | input | 64*NUM_GPR | General registers to capture |
| idx_wr | input | 1 | Index write strobe |
| idx_wdata | input | ADDR_W | New index value |
| abs_max | input | ADDR_W | Absolute buffer limit |
| irq_thresh | input | ADDR_W | Interrupt threshold |
| irq_clr | input | 1 | Clear the interrupt |
| mem_valid | output | 1 | Record word valid |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_data | output | 64 | Record word |
| mem_ready | input | 1 | Memory accepts the word |
| idx_out | output | ADDR_W | Current write index |
| irq | output | 1 | Buffer-nearly-full interrupt |
| buf_full | output | 1 | Sticky buffer-full flag |

## Verification
The colliding case is a counter wrap that lands while the writer is still delivering a record.

The bench provokes it by holding `mem_ready` low, which keeps a record in flight. It then sends a second wrap and releases `mem_ready`. The test passes when exactly two full records appear back to back, the second one exactly one record size above the first, and the index has grown by two records.

The same held-off memory is also used to show two things: an index write during a record is dropped, and dropping the enable does not cut a record short.

// File: rtl/sampwr_pkg.sv
package sampwr_pkg;
    localparam int unsigned WORD_BITS  = 64;
    localparam int unsigned WORD_BYTES = WORD_BITS / 8;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;
endpackage

// File: rtl/sampwr_counter.sv
module sampwr_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             event_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    logic       hit;

    always_comb begin
        cnt_d = cnt_q;
        hit   = en_i && event_i && (cnt_q.cnt == {CNT_W{1'b1}});
        if (load_i) begin
            cnt_d.cnt = preset_i;
        end else if (hit) begin
            cnt_d.cnt = preset_i;
        end else if (en_i && event_i) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wrap_o = hit;
endmodule

// File: rtl/sampwr_recwr.sv
module sampwr_recwr
    import sampwr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_GPR = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wrap_i,
    input  logic [WORD_BITS-1:0]          ip_i,
    input  logic [WORD_BITS-1:0]          flags_i,
    input  logic [NUM_GPR*WORD_BITS-1:0]  gpr_i,
    input  logic                          idx_wr_i,
    input  logic [ADDR_W-1:0]             idx_wdata_i,
    input  logic [ADDR_W-1:0]             abs_max_i,
    input  logic [ADDR_W-1:0]             thresh_i,
    input  logic                          irq_clr_i,
    input  logic                          mem_ready_i,
    output logic                          mem_valid_o,
    output logic [ADDR_W-1:0]             mem_addr_o,
    output logic [WORD_BITS-1:0]          mem_data_o,
    output logic [ADDR_W-1:0]             idx_o,
    output logic                          irq_o,
    output logic                          full_o
);
    localparam int unsigned NUM_WORDS = NUM_GPR + 2;
    localparam int unsigned WCNT_W    = $clog2(NUM_WORDS);
    localparam int unsigned REC_BYTES = NUM_WORDS * WORD_BYTES;
    localparam int unsigned SHIFT     = $clog2(WORD_BYTES);

    typedef struct packed {
        wr_state_e                           st;
        logic [WCNT_W-1:0]                   word;
        logic                                pend;
        logic [ADDR_W-1:0]                   idx;
        logic                                irq;
        logic                                full;
        logic [NUM_WORDS-1:0][WORD_BITS-1:0] snap;
    } wr_state_t;

    wr_state_t                           wr_d, wr_q;
    logic [NUM_WORDS-1:0][WORD_BITS-1:0] snap_in;
    logic                                last_word;
    logic [ADDR_W-1:0]                   idx_next;
    logic                                irq_set;

    always_comb begin
        wr_d      = wr_q;
        irq_set   = 1'b0;
        snap_in   = {gpr_i, flags_i, ip_i};
        last_word = (wr_q.word == WCNT_W'(NUM_WORDS - 1));
        idx_next  = wr_q.idx + ADDR_W'(REC_BYTES);

        case (wr_q.st)
            WR_IDLE: begin
                if (idx_wr_i) begin
                    wr_d.idx  = idx_wdata_i;
                    wr_d.full = 1'b0;
                    wr_d.pend = wr_q.pend | wrap_i;
                end else if (wr_q.pend || wrap_i) begin
                    wr_d.pend = wr_q.pend && wrap_i;
                    if (wr_q.idx >= abs_max_i) begin
                        wr_d.full = 1'b1;
                    end else begin
                        wr_d.st   = WR_BUSY;
                        wr_d.word = '0;
                        wr_d.snap = snap_in;
                    end
                end
            end
            WR_BUSY: begin
                if (wrap_i) wr_d.pend = 1'b1;
                if (mem_ready_i) begin
                    if (last_word) begin
                        wr_d.st  = WR_IDLE;
                        wr_d.idx = idx_next;
                        irq_set  = (idx_next >= thresh_i);
                    end else begin
                        wr_d.word = wr_q.word + 1'b1;
                    end
                end
            end
            default: wr_d.st = WR_IDLE;
        endcase

        if (irq_clr_i) wr_d.irq = 1'b0;
        if (irq_set)   wr_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign mem_valid_o = (wr_q.st == WR_BUSY);
    assign mem_addr_o  = wr_q.idx + (ADDR_W'(wr_q.word) << SHIFT);
    assign mem_data_o  = wr_q.snap[wr_q.word];
    assign idx_o       = wr_q.idx;
    assign irq_o       = wr_q.irq;
    assign full_o      = wr_q.full;
endmodule

// File: rtl/prec_sample_writer.sv
module prec_sample_writer
    import sampwr_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_GPR = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         count_en,
    input  logic                         event_in,
    input  logic                         preset_wr,
    input  logic [CNT_W-1:0]             preset_val,
    input  logic [WORD_BITS-1:0]         state_ip,
    input  logic [WORD_BITS-1:0]         state_flags,
    input  logic [NUM_GPR*WORD_BITS-1:0] state_gpr,
    input  logic                         idx_wr,
    input  logic [ADDR_W-1:0]            idx_wdata,
    input  logic [ADDR_W-1:0]            abs_max,
    input  logic [ADDR_W-1:0]            irq_thresh,
    input  logic                         irq_clr,
    output logic                         mem_valid,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [WORD_BITS-1:0]         mem_data,
    input  logic                         mem_ready,
    output logic [ADDR_W-1:0]            idx_out,
    output logic                         irq,
    output logic                         buf_full
);
    logic wrap;

    sampwr_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (count_en),
        .event_i  (event_in),
        .load_i   (preset_wr),
        .preset_i (preset_val),
        .wrap_o   (wrap)
    );

    sampwr_recwr #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) i_recwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_i      (wrap),
        .ip_i        (state_ip),
        .flags_i     (state_flags),
        .gpr_i       (state_gpr),
        .idx_wr_i    (idx_wr),
        .idx_wdata_i (idx_wdata),
        .abs_max_i   (abs_max),
        .thresh_i    (irq_thresh),
        .irq_clr_i   (irq_clr),
        .mem_ready_i (mem_ready),
        .mem_valid_o (mem_valid),
        .mem_addr_o  (mem_addr),
        .mem_data_o  (mem_data),
        .idx_o       (idx_out),
        .irq_o       (irq),
        .full_o      (buf_full)
    );
endmodule

// File: rtl/sampwr_chk.sv
module sampwr_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_GPR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idx_wr,
    input logic              irq_clr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_data,
    input logic [ADDR_W-1:0] idx_out,
    input logic              irq,
    input logic              buf_full
);
    localparam int unsigned REC_BYTES = (NUM_GPR + 2) * 8;

    logic [ADDR_W-1:0] offs;
    assign offs = mem_addr - idx_out;

    // R4: an offered word holds until taken
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R4: the index moves only when no word is being offered
    a_r4_idx_still_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(idx_out));

    // R3: every word lands inside the record at the current index, word aligned
    a_r3_addr_in_record: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((offs < ADDR_W'(REC_BYTES)) && (offs[2:0] == 3'b000)));

    // R5: the interrupt holds until cleared
    a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R6: the full flag holds without an index write
    a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !idx_wr) |=> buf_full);

    // R10: the index never decreases without an index write
    a_r10_idx_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> (idx_out >= $past(idx_out)));
endmodule

bind prec_sample_writer sampwr_chk #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .irq_clr   (irq_clr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .idx_out   (idx_out),
    .irq       (irq),
    .buf_full  (buf_full)
);

// File: tb/test_prec_sample_writer.sv
module test_prec_sample_writer;
    localparam int CNT_W = 8;
    localparam int ADDR_W = 16;
    localparam int NUM_GPR = 4;
    localparam int NW = NUM_GPR + 2;
    localparam int REC = NW * 8;
    // each vector: {preset[7:0], ip[63:0]}
    localparam logic [71:0] VEC [4] = '{
        {8'hFD, 64'h0000_1000_0000_00A0},
        {8'hF0, 64'hFFFF_8000_1234_5678},
        {8'h80, 64'h0123_4567_89AB_CDEF},
        {8'hFF, 64'hDEAD_BEEF_0000_0004}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic count_en = 1, event_in = 0, preset_wr = 0, idx_wr = 0, irq_clr = 0;
    logic [CNT_W-1:0] preset_val = '0;
    logic [63:0] state_ip = '0, state_flags = '0;
    logic [NUM_GPR*64-1:0] state_gpr = '0;
    logic [ADDR_W-1:0] idx_wdata = '0, abs_max = 16'h0400, irq_thresh = 16'h0300;
    logic mem_valid, mem_ready, irq, buf_full;
    logic [ADDR_W-1:0] mem_addr, idx_out;
    logic [63:0] mem_data;

    int checks = 0, failures = 0;
    int rmode = 0;
    int log_n = 0;
    logic [ADDR_W-1:0] log_addr [64];
    logic [63:0] log_data [64];

    always #2.5 clk = ~clk;

    prec_sample_writer i_prec_sample_writer (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .event_in(event_in),
        .preset_wr(preset_wr), .preset_val(preset_val), .state_ip(state_ip),
        .state_flags(state_flags), .state_gpr(state_gpr), .idx_wr(idx_wr),
        .idx_wdata(idx_wdata), .abs_max(abs_max), .irq_thresh(irq_thresh),
        .irq_clr(irq_clr), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ready(mem_ready), .idx_out(idx_out),
        .irq(irq), .buf_full(buf_full)
    );

    logic rdy_r = 1'b1;
    always @(posedge clk) begin
        case (rmode)
            0: rdy_r <= 1'b1;
            1: rdy_r <= ~rdy_r;
            default: rdy_r <= 1'b0;
        endcase
    end
    assign mem_ready = rdy_r;

    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && log_n < 64) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_data;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input logic [63:0] ip, input int j);
        if (j == 0) return ip;
        if (j == 1) return ~ip;
        return ip ^ (64'(j - 1) * 64'h1111);
    endfunction

    task automatic set_state(input logic [63:0] ip);
        state_ip = ip;
        state_flags = ~ip;
        for (int k = 0; k < NUM_GPR; k++) state_gpr[k*64 +: 64] = ip ^ (64'(k + 1) * 64'h1111);
    endtask

    task automatic evt(input int n);
        if (n > 0) begin
            event_in = 1;
            repeat (n) @(negedge clk);
            event_in = 0;
        end
    endtask

    task automatic load_preset(input logic [7:0] p);
        preset_val = p; preset_wr = 1;
        @(negedge clk);
        preset_wr = 0;
    endtask

    task automatic set_idx(input logic [ADDR_W-1:0] v);
        idx_wdata = v; idx_wr = 1;
        @(negedge clk);
        idx_wr = 0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 400 && mem_valid; t++) @(negedge clk);
    endtask

    task automatic check_record(input int first, input logic [ADDR_W-1:0] base, input logic [63:0] ip, input string req);
        for (int j = 0; j < NW; j++) begin
            chk(log_addr[first+j] == base + ADDR_W'(8*j), req, 64'(log_addr[first+j]), 64'(base + ADDR_W'(8*j)));
            chk(log_data[first+j] == exp_word(ip, j), req, log_data[first+j], exp_word(ip, j));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] base;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_valid == 0, "R1 mem_valid", 64'(mem_valid), 0);
        chk(irq == 0, "R1 irq", 64'(irq), 0);
        chk(buf_full == 0, "R1 buf_full", 64'(buf_full), 0);
        chk(idx_out == 0, "R1 idx_out", 64'(idx_out), 0);
        rst_n = 1;
        @(negedge clk);
        set_idx(16'h0100);

        // table of vectors: R2 count, R3 record, R4 index advance
        for (int v = 0; v < 4; v++) begin
            logic [7:0] p;
            logic [63:0] ip;
            int n;
            p = VEC[v][71:64];
            ip = VEC[v][63:0];
            n = 256 - int'(p);
            rmode = v % 2;
            set_state(ip);
            load_preset(p);
            log_n = 0;
            base = idx_out;
            evt(n - 1);
            repeat (2) @(negedge clk);
            chk(log_n == 0 && !mem_valid, "R2 no wrap before count", 64'(log_n), 0);
            evt(1);
            wait_idle();
            chk(log_n == NW, "R3 word count", 64'(log_n), 64'(NW));
            check_record(0, base, ip, "R3 record");
            chk(idx_out == base + REC, "R4 index advance", 64'(idx_out), 64'(base + REC));
        end
        rmode = 0;
        chk(irq == 0, "R5 irq below threshold", 64'(irq), 0);

        // R5: crossing the threshold sets irq in the same cycle as the index
        irq_thresh = idx_out + REC;
        load_preset(8'hFF);
        set_state(64'h55);
        evt(1);
        wait_idle();
        chk(irq == 1, "R5 irq set", 64'(irq), 1);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        chk(irq == 0, "R5 irq cleared", 64'(irq), 0);
        evt(1);
        wait_idle();
        chk(irq == 1, "R5 irq set again", 64'(irq), 1);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        irq_thresh = 16'hFFF0;

        // R9: index write ignored while a record is in flight
        rmode = 2;
        base = idx_out;
        log_n = 0;
        evt(1);
        set_idx(16'h0010);
        rmode = 0;
        wait_idle();
        chk(idx_out == base + REC, "R9 index write ignored", 64'(idx_out), 64'(base + REC));

        // R7: wrap during a record is kept and serviced afterwards
        rmode = 2;
        base = idx_out;
        log_n = 0;
        set_state(64'h77);
        evt(1);
        repeat (2) @(negedge clk);
        evt(1);
        repeat (2) @(negedge clk);
        rmode = 0;
        repeat (40) @(negedge clk);
        chk(log_n == 2 * NW, "R7 two records", 64'(log_n), 64'(2 * NW));
        check_record(NW, base + REC, 64'h77, "R7 second record");
        chk(idx_out == base + 2 * REC, "R7 index", 64'(idx_out), 64'(base + 2 * REC));

        // R8: disabled counting ignores events; disabling mid-record completes it
        count_en = 0;
        log_n = 0;
        evt(5);
        repeat (3) @(negedge clk);
        chk(log_n == 0 && !mem_valid, "R8 no count when disabled", 64'(log_n), 0);
        count_en = 1;
        rmode = 2;
        base = idx_out;
        evt(1);
        count_en = 0;
        repeat (2) @(negedge clk);
        rmode = 0;
        wait_idle();
        chk(log_n == NW, "R8 record completes", 64'(log_n), 64'(NW));
        chk(idx_out == base + REC, "R8 index", 64'(idx_out), 64'(base + REC));
        count_en = 1;

        // R6: at the limit no record, sticky full, counter still reloads
        abs_max = idx_out;
        base = idx_out;
        load_preset(8'hFD);
        log_n = 0;
        evt(3);
        repeat (3) @(negedge clk);
        chk(log_n == 0, "R6 no write at limit", 64'(log_n), 0);
        chk(buf_full == 1, "R6 full set", 64'(buf_full), 1);
        chk(idx_out == base, "R6 index unchanged", 64'(idx_out), 64'(base));
        evt(3);
        repeat (3) @(negedge clk);
        chk(buf_full == 1 && log_n == 0, "R6 full sticky", 64'(buf_full), 1);
        set_idx(base);
        chk(buf_full == 0, "R6 full cleared by index write", 64'(buf_full), 0);
        abs_max = 16'h0F00;
        evt(2);
        repeat (3) @(negedge clk);
        chk(log_n == 0, "R6 reload kept count", 64'(log_n), 0);
        evt(1);
        wait_idle();
        chk(log_n == NW, "R6 record after reload", 64'(log_n), 64'(NW));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule